// File: doc/BRIEF.md
# Linear-Regulator Rail Enable and Discharge Controller

This block decides, for each of four linear-regulator rails, whether the pass device is switched on and whether the active output pull-down is switched on. The on/off source of every rail depends on the power state. In ACTIVE a rail follows its active-enable bit. In STBY it follows its standby-enable bit. In OFF and INITIALIZE every rail is held off. A held discharge configuration decides whether a disabled rail is pulled down. A sequencing strobe forces every disabled rail to discharge ahead of a move into ACTIVE, so that no rail starts into a pre-biased output.

Software can also request a rail on over I2C while in ACTIVE. Such a request forces no discharge. It is granted only once the rail's comparator reports the output below the short-to-ground threshold, and it stays pending until then or until it is withdrawn. The block also holds a per-rail operating-mode code, where changes between regulator and load-switch classes are refused while the rail runs. It routes one voltage-select source, taken from a pin through a polarity bit or from an I2C bit, to a chosen rail.

All outputs are registered, so each one follows its inputs one clock later. The synchronous reset is the OFF condition.

Top module: `rail_ctl`

## Requirements
- R1: With pwr_state = 2 (ACTIVE), and no I2C grant, rail_en equals act_en one clock after the inputs are applied.
- R2: With pwr_state = 3 (STBY), rail_en equals stby_en one clock later, and act_en and the I2C requests have no effect.
- R3: With pwr_state = 1 (INITIALIZE) or 0 (OFF), rail_en is 0 for every rail, whatever act_en, stby_en and i2c_req hold.
- R4: An enabled rail never has rail_dis set. A disabled rail has rail_dis equal to its held discharge-configuration bit when seq_to_active is low.
- R5: While seq_to_active is high, every rail whose next rail_en is 0 has rail_dis set one clock later, even if its configuration bit is 0.
- R6: In ACTIVE, a rail with i2c_req set and act_en clear turns on only in the clock after below_scg for that rail is seen high. The request stays pending while below_scg is low. Once granted, the rail stays on until i2c_req drops. A request withdrawn before below_scg rises never turns the rail on.
- R7: The discharge configuration is loaded from dis_cfg_in on dis_cfg_wr outside OFF. It returns to all ones (discharge on) on reset and in every clock where pwr_state = 0 (OFF). It is kept unchanged through INITIALIZE.
- R8: rail_mode holds a 2-bit code per rail r at bits [2r+1:2r] (00 regulator, 01 bypass, 1x load switch). A mode_wr changing bit 1 of the code is ignored while that rail's rail_en is 1. A change within the regulator/bypass class is accepted at any time. All codes reset to 00.
- R9: vsel_out has at most one bit set, at index vsel_rail, equal to vsel_i2c when vsel_use_i2c = 1 and to vsel_pin XOR vsel_pol otherwise. This is one clock later.
- R10: After reset rail_en = 0000, rail_dis = 1111, rail_mode = 0 and vsel_out = 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high (OFF condition) |
| pwr_state | input | 2 | 0 OFF, 1 INITIALIZE, 2 ACTIVE, 3 STBY |
| act_en | input | 4 | Per-rail enable used in ACTIVE |
| stby_en | input | 4 | Per-rail enable used in STBY |
| seq_to_active | input | 1 | High while a sequence into ACTIVE is under way |
| dis_cfg_wr | input | 1 | Load strobe for the discharge configuration |
| dis_cfg_in | input | 4 | New discharge configuration, 1 = pull-down allowed |
| i2c_req | input | 4 | Per-rail I2C enable request, level |
| below_scg | input | 4 | Per-rail flag: output below short-to-ground threshold |
| mode_wr | input | 1 | Mode-code write strobe |
| mode_rail | input | 2 | Rail targeted by mode_wr |
| mode_code | input | 2 | New mode code |
| vsel_pin | input | 1 | Voltage-select pin |
| vsel_pol | input | 1 | Polarity inversion for vsel_pin |
| vsel_use_i2c | input | 1 | 1 = take the select from vsel_i2c |
| vsel_i2c | input | 1 | Software voltage-select bit |
| vsel_rail | input | 2 | Rail that the voltage select drives |
| rail_en | output | 4 | Pass device on, per rail |
| rail_dis | output | 4 | Discharge pull-down on, per rail |
| rail_mode | output | 8 | Held mode code, rail r at [2r+1:2r] |
| vsel_out | output | 4 | Alternate-voltage select, per rail |

## Verification
Every cycle, the assertions check that enable and discharge are never set together on a rail. They also check that INITIALIZE and OFF leave every rail off, that the sequencing strobe discharges each disabled rail, and that a class-changing mode write to a running rail leaves its code unchanged. In addition, they check that an I2C-only turn-on in ACTIVE is preceded by the below-threshold flag and that the voltage select never reaches two rails. The bench scenarios show what the properties cannot state in general. These are the per-state source selection over a table of patterns, the clearing of the discharge configuration in OFF versus its retention through INITIALIZE, a pending I2C request that is withdrawn, and the pin-polarity and rail routing of the voltage select.

// File: rtl/rail_ctl.sv
module rail_ctl #(
  parameter int NR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      pwr_state,
  input  logic [NR-1:0]   act_en,
  input  logic [NR-1:0]   stby_en,
  input  logic            seq_to_active,
  input  logic            dis_cfg_wr,
  input  logic [NR-1:0]   dis_cfg_in,
  input  logic [NR-1:0]   i2c_req,
  input  logic [NR-1:0]   below_scg,
  input  logic            mode_wr,
  input  logic [1:0]      mode_rail,
  input  logic [1:0]      mode_code,
  input  logic            vsel_pin,
  input  logic            vsel_pol,
  input  logic            vsel_use_i2c,
  input  logic            vsel_i2c,
  input  logic [1:0]      vsel_rail,
  output logic [NR-1:0]   rail_en,
  output logic [NR-1:0]   rail_dis,
  output logic [2*NR-1:0] rail_mode,
  output logic [NR-1:0]   vsel_out
);
  localparam logic [1:0] ST_OFF = 2'd0, ST_INIT = 2'd1, ST_ACT = 2'd2, ST_STBY = 2'd3;

  logic [NR-1:0] cfg_q, grant_q, grant_n, en_n;
  logic          vsel_src;

  assign grant_n = (pwr_state == ST_ACT) ? (i2c_req & (grant_q | below_scg)) : '0;

  always_comb begin
    case (pwr_state)
      ST_ACT:  en_n = act_en | grant_n;
      ST_STBY: en_n = stby_en;
      default: en_n = '0;
    endcase
  end

  assign vsel_src = vsel_use_i2c ? vsel_i2c : (vsel_pin ^ vsel_pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '1;
      grant_q  <= '0;
      rail_en  <= '0;
      rail_dis <= '1;
      vsel_out <= '0;
    end else begin
      grant_q  <= grant_n;
      rail_en  <= en_n;
      rail_dis <= ~en_n & (cfg_q | {NR{seq_to_active}});
      vsel_out <= NR'(vsel_src) << vsel_rail;
      if (pwr_state == ST_OFF) cfg_q <= '1;
      else if (dis_cfg_wr)     cfg_q <= dis_cfg_in;
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_mode
    logic ok;
    assign ok = (mode_code[1] == rail_mode[2*r+1]) || !rail_en[r];
    always_ff @(posedge clk) begin
      if (rst)
        rail_mode[2*r +: 2] <= 2'b00;
      else if (mode_wr && mode_rail == 2'(r) && ok)
        rail_mode[2*r +: 2] <= mode_code;
    end
  end
endmodule

module rail_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] pwr_state,
  input logic [3:0] act_en,
  input logic       seq_to_active,
  input logic [3:0] i2c_req,
  input logic [3:0] below_scg,
  input logic       mode_wr,
  input logic [1:0] mode_rail,
  input logic [1:0] mode_code,
  input logic [3:0] rail_en,
  input logic [3:0] rail_dis,
  input logic [7:0] rail_mode,
  input logic [3:0] vsel_out
);
  logic [1:0] cur_code;
  assign cur_code = 2'(rail_mode >> {mode_rail, 1'b0});

  // R4
  en_dis_excl_chk: assert property (@(posedge clk) disable iff (rst) (rail_en & rail_dis) == 4'b0);
  // R3
  init_off_chk: assert property (@(posedge clk) disable iff (rst) pwr_state[1] == 1'b0 |=> rail_en == 4'b0);
  // R5
  seq_dis_chk: assert property (@(posedge clk) disable iff (rst) seq_to_active |=> (rail_dis | rail_en) == 4'b1111);
  // R8
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr && rail_en[mode_rail] && (mode_code[1] != cur_code[1]) |=> $stable(rail_mode));
  // R9
  vsel_one_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(vsel_out));
  // R6
  i2c_gate0_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rail_en[0]) && $past(pwr_state) == 2'd2 && !$past(act_en[0]) |-> $past(below_scg[0]) && $past(i2c_req[0]));
endmodule

bind rail_ctl rail_ctl_chk u_chk (.*);

// File: tb/tb_rail_ctl.sv
module tb_rail_ctl;
  logic clk = 0, rst = 1;
  logic [1:0] pwr_state = 0;
  logic [3:0] act_en = 0, stby_en = 0, dis_cfg_in = 0, i2c_req = 0, below_scg = 0;
  logic seq_to_active = 0, dis_cfg_wr = 0, mode_wr = 0;
  logic [1:0] mode_rail = 0, mode_code = 0, vsel_rail = 0;
  logic vsel_pin = 0, vsel_pol = 0, vsel_use_i2c = 0, vsel_i2c = 0;
  logic [3:0] rail_en, rail_dis, vsel_out;
  logic [7:0] rail_mode;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  rail_ctl dut (.*);

  // {state, act, stby, seq, exp_en, exp_dis}
  localparam logic [18:0] VEC [8] = '{
    {2'd2, 4'b1100, 4'b0000, 1'b0, 4'b1100, 4'b0001},
    {2'd2, 4'b0011, 4'b0000, 1'b1, 4'b0011, 4'b1100},
    {2'd3, 4'b1111, 4'b1010, 1'b0, 4'b1010, 4'b0101},
    {2'd3, 4'b1111, 4'b0000, 1'b1, 4'b0000, 4'b1111},
    {2'd1, 4'b1111, 4'b1111, 1'b0, 4'b0000, 4'b0101},
    {2'd1, 4'b1111, 4'b1111, 1'b1, 4'b0000, 4'b1111},
    {2'd2, 4'b1111, 4'b0000, 1'b0, 4'b1111, 4'b0000},
    {2'd2, 4'b0000, 4'b1111, 1'b0, 4'b0000, 4'b0101}
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick; tick; rst = 0;
    chk("R10 en", {4'b0, rail_en}, 8'h00);
    chk("R10 dis", {4'b0, rail_dis}, 8'h0F);
    chk("R10 mode", rail_mode, 8'h00);
    chk("R10 vsel", {4'b0, vsel_out}, 8'h00);

    pwr_state = 1; dis_cfg_wr = 1; dis_cfg_in = 4'b0101; tick; dis_cfg_wr = 0;
    for (int i = 0; i < 8; i++) begin
      {pwr_state, act_en, stby_en, seq_to_active} = VEC[i][18:8];
      tick;
      chk("R1/R2/R3 en", {4'b0, rail_en}, {4'b0, VEC[i][7:4]});
      chk("R4/R5/R7 dis", {4'b0, rail_dis}, {4'b0, VEC[i][3:0]});
    end

    // R7: OFF restores configuration
    pwr_state = 0; tick;
    chk("R3 off en", {4'b0, rail_en}, 8'h00);
    pwr_state = 1; tick;
    chk("R7 cfg after OFF", {4'b0, rail_dis}, 8'h0F);

    // R6: I2C enable gated on below_scg
    pwr_state = 2; act_en = 0; dis_cfg_wr = 1; dis_cfg_in = 4'b0000; i2c_req = 4'b0001; tick; dis_cfg_wr = 0;
    tick; tick;
    chk("R6 pending", {4'b0, rail_en}, 8'h00);
    chk("R6 no forced dis", {4'b0, rail_dis}, 8'h00);
    below_scg = 4'b0001; tick;
    chk("R6 granted", {4'b0, rail_en}, 8'h01);
    below_scg = 0; tick;
    chk("R6 held", {4'b0, rail_en}, 8'h01);
    i2c_req = 0; tick;
    chk("R6 withdrawn", {4'b0, rail_en}, 8'h00);
    i2c_req = 4'b0010; tick; i2c_req = 0; tick; below_scg = 4'b0010; tick;
    chk("R6 cancelled", {4'b0, rail_en}, 8'h00);
    below_scg = 0;
    pwr_state = 3; stby_en = 0; i2c_req = 4'b0100; below_scg = 4'b0100; tick;
    chk("R2 i2c ignored in STBY", {4'b0, rail_en}, 8'h00);
    i2c_req = 0; below_scg = 0;

    // R8: mode-class lock
    pwr_state = 2; act_en = 4'b0001; tick;
    mode_wr = 1; mode_rail = 0; mode_code = 2'b10; tick; mode_wr = 0;
    chk("R8 lsw refused", rail_mode, 8'h00);
    mode_wr = 1; mode_code = 2'b01; tick; mode_wr = 0;
    chk("R8 bypass accepted", rail_mode, 8'h01);
    act_en = 0; tick;
    mode_wr = 1; mode_code = 2'b10; tick; mode_wr = 0;
    chk("R8 lsw when off", rail_mode, 8'h02);
    mode_wr = 1; mode_rail = 3; mode_code = 2'b11; tick; mode_wr = 0;
    chk("R8 rail3", rail_mode, 8'hC2);

    // R9: voltage select
    vsel_rail = 2; vsel_pin = 1; vsel_pol = 0; tick;
    chk("R9 pin", {4'b0, vsel_out}, 8'h04);
    vsel_pol = 1; tick;
    chk("R9 pol", {4'b0, vsel_out}, 8'h00);
    vsel_use_i2c = 1; vsel_i2c = 1; tick;
    chk("R9 i2c", {4'b0, vsel_out}, 8'h04);
    vsel_rail = 3; tick;
    chk("R9 rail", {4'b0, vsel_out}, 8'h08);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule